// File: doc/BRIEF.md
# Node Performance Monitor

This block is a small hardware monitor that sits beside one processor in a multiprocessor node. Six single-cycle event strobes from the rest of the node each drive a 32-bit counter of their own: retired instructions, cache hits, cache misses, local memory references, remote memory references and translation-buffer misses. The processor reaches every counter through a simple register bus. It can read any counter, and it can load a counter with any value. Writing zero resets it.

Beside the counters, a sampler measures the time the interconnect takes to answer remote requests. A programmable interval timer arms the sampler once per period. The next remote request issued after that point is timed in clock cycles until its response strobe returns. Each finished sample adds to a running latency sum and a sample count, and the largest sample seen is kept. A global enable bit stops every counter and the sampler, so that software can take a consistent snapshot. Counter wrap-around sets sticky flags, and these flags can raise an interrupt.

Top module: `node_perf_monitor`

## Requirements
- R1: After reset, every counter reads 0. The control, overflow-flag, interval, latency-sum, sample-count and max-latency registers also read 0, and irq_o is 0.
- R2: While the enable bit is set, a high strobe on evt_i[i] in a cycle adds one to counter i. Counter i is at address i. The bit order is: 0 retired instructions, 1 cache hits, 2 cache misses, 3 local references, 4 remote references, 5 translation misses.
- R3: A register write to a counter address (0 to 5) loads that counter with reg_wdata_i. When an event for the same counter arrives in the same cycle, the write takes effect and the event is lost.
- R4: Bit 0 of the control register at address 6 is the global enable. While it is 0, no counter changes on events. The sampler also drops to idle, which abandons any sample in progress and restarts the interval timer.
- R5: A counter at 32'hFFFFFFFF that takes an event wraps to 0. The wrap sets bit i of the sticky flag register at address 7. Writing 1 to a flag bit clears it, and a new wrap in the same cycle wins over the clear.
- R6: irq_o is high exactly when bit 1 of the control register is set and at least one overflow flag is set.
- R7: The interval register is at address 8. While the monitor is enabled and the interval N is nonzero, the sampler arms after N idle clocks. An interval of 0 never arms it.
- R8: When armed, the next remote issue strobe starts a measurement. The response strobe k cycles later (k >= 1) adds k to the latency sum (address 9), adds one to the sample count (address 10), and raises the max-latency register (address 11) if k exceeds it. Issue strobes while not armed and response strobes while not measuring are ignored.
- R9: A write to address 9, 10 or 11 loads that register with reg_wdata_i. A write takes priority over a sample that completes in the same cycle.
- R10: Reads from addresses 12 to 15 return 0. The read data is combinational from reg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 6 | Single-cycle event strobes, one per counter |
| rreq_issue_i | input | 1 | Strobe: a remote request left the node |
| rrsp_return_i | input | 1 | Strobe: a remote response arrived |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The assertions assume three things about the inputs. At most one remote request is outstanding at a time. A response never arrives in the same cycle as its issue. Event strobes are sampled once per clock as levels, so a strobe held high for n cycles counts n events. The bench pulses each strobe for exactly one cycle. It sends a response only after its own issue, at least one cycle later, and it deliberately adds stray issue and response strobes only while the sampler is idle, to check that they are ignored.

// File: rtl/pm_pkg.sv
// Shared constants and types for the node performance monitor.
// Assumes a word-addressed register bus with a 4-bit address.
package pm_pkg;
    localparam int PM_NUM_EVT = 6;
    localparam int PM_CNT_W   = 32;
    localparam int PM_ADDR_W  = 4;

    // Register word addresses above the counter block
    localparam int PM_A_CTRL = 6;
    localparam int PM_A_OVF  = 7;
    localparam int PM_A_INTV = 8;
    localparam int PM_A_LSUM = 9;
    localparam int PM_A_LCNT = 10;
    localparam int PM_A_LMAX = 11;

    typedef enum logic [1:0] {
        SMP_IDLE  = 2'd0,
        SMP_ARMED = 2'd1,
        SMP_MEAS  = 2'd2
    } smp_state_t;
endpackage

// File: rtl/pm_evt_counter.sv
// One wrapping event counter with a software load port.
// Assumes evt is a level sampled once per clock; a load beats a same-cycle event.
module pm_evt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic         evt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic inc;

    // An increment happens only when enabled and no load is pending
    assign inc    = count_en && evt && !wr_en;
    // Wrap is flagged in the cycle the all-ones value rolls over
    assign wrap_o = inc && (cnt_o == {W{1'b1}});

    // Counter register: load, increment or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (wr_en) begin
            cnt_o <= wr_data;
        end else if (inc) begin
            cnt_o <= cnt_o + W'(1);
        end
    end

    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_o == $past(wr_data)));

    a_r2_event_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && evt && !wr_en) |=> (cnt_o == $past(cnt_o) + W'(1)));

    a_r4_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !wr_en) |=> $stable(cnt_o));
endmodule

// File: rtl/pm_lat_sampler.sv
// Interval-armed latency sampler for remote requests.
// Assumes one outstanding remote request and a response no earlier than
// one cycle after its issue strobe. Dropping run_en abandons any sample.
module pm_lat_sampler
    import pm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] interval,
    input  logic         issue,
    input  logic         resp,
    input  logic         wr_sum,
    input  logic         wr_cnt,
    input  logic         wr_max,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] max_o
);
    smp_state_t  state_q;
    logic [W-1:0] timer_q;
    logic [W-1:0] lat_q;
    logic         done;

    // A sample finishes when a response arrives during a measurement
    assign done = run_en && (state_q == SMP_MEAS) && resp;

    // Interval timer, arming and latency measurement
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            state_q <= SMP_IDLE;
            timer_q <= '0;
            lat_q   <= '0;
        end else begin
            case (state_q)
                SMP_IDLE: begin
                    if (interval == '0) begin
                        timer_q <= '0;
                    end else if (timer_q >= interval - W'(1)) begin
                        timer_q <= '0;
                        state_q <= SMP_ARMED;
                    end else begin
                        timer_q <= timer_q + W'(1);
                    end
                end
                SMP_ARMED: begin
                    if (issue) begin
                        state_q <= SMP_MEAS;
                        lat_q   <= W'(1);
                    end
                end
                SMP_MEAS: begin
                    if (resp) begin
                        state_q <= SMP_IDLE;
                        lat_q   <= '0;
                    end else if (lat_q != {W{1'b1}}) begin
                        lat_q <= lat_q + W'(1);
                    end
                end
                default: state_q <= SMP_IDLE;
            endcase
        end
    end

    // Latency sum: software load has priority over accumulation
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_o <= '0;
        else if (wr_sum) sum_o <= wr_data;
        else if (done)   sum_o <= sum_o + lat_q;
    end

    // Sample count: software load has priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (wr_cnt) cnt_o <= wr_data;
        else if (done)   cnt_o <= cnt_o + W'(1);
    end

    // Largest latency seen: software load has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                      max_o <= '0;
        else if (wr_max)                 max_o <= wr_data;
        else if (done && lat_q > max_o)  max_o <= lat_q;
    end

    a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_cnt) |=> (cnt_o == $past(cnt_o) + W'(1)));

    a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !wr_cnt) |=> $stable(cnt_o));

    a_r8_max_rises_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_max) |=> (max_o >= $past(max_o)));

    a_r4_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en) |=> (state_q == SMP_IDLE));

    a_r7_zero_never_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0 && state_q == SMP_IDLE) |=> (state_q == SMP_IDLE));
endmodule

// File: rtl/node_perf_monitor.sv
// Per-processor performance monitor: event counters, remote latency
// sampler and register decode. Assumes single-cycle event strobes and
// a word-addressed bus whose read data follows the address combinationally.
module node_perf_monitor
    import pm_pkg::*;
#(
    parameter int NUM_EVT = PM_NUM_EVT,
    parameter int CNT_W   = PM_CNT_W,
    parameter int ADDR_W  = PM_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              rreq_issue_i,
    input  logic              rrsp_return_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(PM_A_CTRL);
    localparam logic [ADDR_W-1:0] AD_OVF  = ADDR_W'(PM_A_OVF);
    localparam logic [ADDR_W-1:0] AD_INTV = ADDR_W'(PM_A_INTV);
    localparam logic [ADDR_W-1:0] AD_LSUM = ADDR_W'(PM_A_LSUM);
    localparam logic [ADDR_W-1:0] AD_LCNT = ADDR_W'(PM_A_LCNT);
    localparam logic [ADDR_W-1:0] AD_LMAX = ADDR_W'(PM_A_LMAX);

    logic [1:0]         ctrl_q;
    logic [NUM_EVT-1:0] ovf_q;
    logic [CNT_W-1:0]   interval_q;
    logic [NUM_EVT-1:0] wr_hit;
    logic [NUM_EVT-1:0] wrap_vec;
    logic [NUM_EVT-1:0] ovf_clr;
    logic [CNT_W-1:0]   cnt_arr [NUM_EVT];
    logic [CNT_W-1:0]   lat_sum, lat_cnt, lat_max;
    logic               glb_en;

    assign glb_en = ctrl_q[0];

    genvar g;
    generate
        for (g = 0; g < NUM_EVT; g++) begin : g_cnt
            assign wr_hit[g] = reg_wr_i && (reg_addr_i == ADDR_W'(g));
            pm_evt_counter #(.W(CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .count_en(glb_en),
                .evt     (evt_i[g]),
                .wr_en   (wr_hit[g]),
                .wr_data (reg_wdata_i),
                .cnt_o   (cnt_arr[g]),
                .wrap_o  (wrap_vec[g])
            );
        end
    endgenerate

    pm_lat_sampler #(.W(CNT_W)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (glb_en),
        .interval(interval_q),
        .issue   (rreq_issue_i),
        .resp    (rrsp_return_i),
        .wr_sum  (reg_wr_i && reg_addr_i == AD_LSUM),
        .wr_cnt  (reg_wr_i && reg_addr_i == AD_LCNT),
        .wr_max  (reg_wr_i && reg_addr_i == AD_LMAX),
        .wr_data (reg_wdata_i),
        .sum_o   (lat_sum),
        .cnt_o   (lat_cnt),
        .max_o   (lat_max)
    );

    // Write-one-to-clear mask for the sticky overflow flags
    assign ovf_clr = (reg_wr_i && reg_addr_i == AD_OVF) ? reg_wdata_i[NUM_EVT-1:0] : '0;

    // Control and interval registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            interval_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == AD_CTRL) ctrl_q     <= reg_wdata_i[1:0];
            if (reg_addr_i == AD_INTV) interval_q <= reg_wdata_i;
        end
    end

    // Sticky overflow flags: a new wrap wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
    end

    assign irq_o = ctrl_q[1] && (|ovf_q);

    // Read multiplexer over counters and control registers
    always_comb begin
        reg_rdata_o = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (reg_addr_i == ADDR_W'(i)) reg_rdata_o = cnt_arr[i];
        end
        case (reg_addr_i)
            AD_CTRL: reg_rdata_o[1:0]         = ctrl_q;
            AD_OVF:  reg_rdata_o[NUM_EVT-1:0] = ovf_q;
            AD_INTV: reg_rdata_o              = interval_q;
            AD_LSUM: reg_rdata_o              = lat_sum;
            AD_LCNT: reg_rdata_o              = lat_cnt;
            AD_LMAX: reg_rdata_o              = lat_max;
            default: ;
        endcase
    end

    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr == '0) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));
endmodule

// File: tb/node_perf_monitor_tb.sv
// Directed bench for the node performance monitor.
module node_perf_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  evt;
    logic        issue, resp, reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] wdata, rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] exp_cnt [6];

    node_perf_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .rreq_issue_i(issue), .rrsp_return_i(resp),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 4'(a); wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 4'(a);
        #1;
        v = rdata;
    endtask

    task automatic pulse(input logic [5:0] m);
        evt = m;
        tick();
        evt = '0;
        for (int i = 0; i < 6; i++) if (m[i]) exp_cnt[i]++;
    endtask

    task automatic check_counters(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 6; i++) begin
            rd(i, v);
            chk(tag, v, exp_cnt[i]);
        end
    endtask

    // One sample: issue, then response k cycles later
    task automatic sample(input int k);
        issue = 1'b1; tick(); issue = 1'b0;
        repeat (k - 1) tick();
        resp = 1'b1; tick(); resp = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 12; a++) begin
            rd(a, v);
            chk("R1 reset value", v, 32'd0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_events();
        wr(6, 32'd1);
        repeat (3) pulse(6'b000001);
        repeat (2) pulse(6'b101010);
        pulse(6'b111111);
        pulse(6'b010100);
        check_counters("R2 per-event counts");
    endtask

    task automatic t_write_wins();
        logic [31:0] v;
        reg_wr = 1'b1; reg_addr = 4'd2; wdata = 32'd100; evt = 6'b000100;
        tick();
        reg_wr = 1'b0; evt = '0;
        rd(2, v); chk("R3 write beats event", v, 32'd100);
        exp_cnt[2] = 32'd100;
        pulse(6'b000100);
        rd(2, v); chk("R3 counts on from loaded value", v, 32'd101);
        wr(4, 32'd0); exp_cnt[4] = 0;
        check_counters("R3 reset by writing zero");
    endtask

    task automatic t_freeze();
        wr(6, 32'd0);
        evt = 6'b111111; tick(); tick(); evt = '0;
        check_counters("R4 frozen counters hold");
        wr(6, 32'd1);
        pulse(6'b000010);
        check_counters("R4 counting resumes");
    endtask

    task automatic t_wrap_irq();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFE); exp_cnt[0] = 32'hFFFF_FFFE;
        pulse(6'b000001);
        rd(7, v); chk("R5 no flag before wrap", v, 32'd0);
        pulse(6'b000001);
        rd(0, v); chk("R5 wrapped to zero", v, 32'd0);
        rd(7, v); chk("R5 flag bit0 set", v, 32'd1);
        chk("R6 irq masked when disabled", {31'd0, irq}, 32'd0);
        wr(6, 32'd3);
        chk("R6 irq raised", {31'd0, irq}, 32'd1);
        wr(7, 32'd0);
        rd(7, v); chk("R5 write zero keeps flag", v, 32'd1);
        wr(7, 32'd1);
        rd(7, v); chk("R5 write one clears flag", v, 32'd0);
        chk("R6 irq drops", {31'd0, irq}, 32'd0);
        wr(6, 32'd1);
    endtask

    task automatic t_sampler();
        logic [31:0] v;
        repeat (12) tick();
        issue = 1'b1; tick(); issue = 1'b0;
        resp = 1'b1; tick(); resp = 1'b0;
        rd(10, v); chk("R7 zero interval never samples", v, 32'd0);
        wr(8, 32'd4);
        repeat (8) tick();
        sample(7);
        rd(9, v);  chk("R8 sum after first", v, 32'd7);
        rd(10, v); chk("R8 count after first", v, 32'd1);
        rd(11, v); chk("R8 max after first", v, 32'd7);
        sample(2);
        rd(10, v); chk("R8 issue while not armed ignored", v, 32'd1);
        repeat (8) tick();
        sample(3);
        rd(9, v);  chk("R8 sum after second", v, 32'd10);
        rd(11, v); chk("R8 max kept", v, 32'd7);
        repeat (8) tick();
        sample(12);
        rd(9, v);  chk("R8 sum after third", v, 32'd22);
        rd(10, v); chk("R8 count after third", v, 32'd3);
        rd(11, v); chk("R8 max raised", v, 32'd12);
        repeat (8) tick();
        issue = 1'b1; tick(); issue = 1'b0;
        tick();
        wr(6, 32'd0); wr(6, 32'd1);
        resp = 1'b1; tick(); resp = 1'b0;
        rd(10, v); chk("R4 disable abandons sample", v, 32'd3);
        wr(9, 32'd0); wr(10, 32'd0); wr(11, 32'd5);
        rd(9, v);  chk("R9 sum loaded", v, 32'd0);
        rd(10, v); chk("R9 count loaded", v, 32'd0);
        rd(11, v); chk("R9 max loaded", v, 32'd5);
        rd(8, v);  chk("R7 interval readback", v, 32'd4);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        for (int a = 12; a < 16; a++) begin
            rd(a, v);
            chk("R10 unmapped reads zero", v, 32'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0; evt = '0; issue = 0; resp = 0; reg_wr = 0; reg_addr = '0; wdata = '0;
        for (int i = 0; i < 6; i++) exp_cnt[i] = '0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_events();
        t_write_wins();
        t_freeze();
        t_wrap_irq();
        t_sampler();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule